// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block combines a byte-wide scratch memory with a calendar clock. The clock registers occupy the top eight byte addresses of the address space. A host reaches both through one asynchronous-style memory port with three active-low strobes: chip enable, output enable and write enable. The RTL samples these strobes on the system clock. Any address below the clock window goes to a plain RAM.

The clock holds eight packed-BCD registers: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and century. An external one-cycle strobe marks each second. A carry chain moves each tick through the calendar, with month lengths and the leap-year rule applied, including the case where the year rolls from 99 to 00. A host write to a clock register takes effect on the clock edge that samples it. A read returns a snapshot that does not change for the rest of the access, even while the clock keeps counting.

Top module: `bcd_rtc_sram`

## Requirements
- R1: Byte addresses 0x7FF8 to 0x7FFF select the clock registers, with the low three address bits giving the register: 0 century, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. Every other address selects RAM. The RAM stores 2^RAM_AW bytes (2048 by default), indexed by the low RAM_AW address bits, so higher RAM addresses alias onto lower ones.
- R2: A RAM read returns the byte last written to the same RAM location. RAM contents are not cleared by reset.
- R3: After reset the clock reads century 0x20, year 0x00, month 0x01, date 0x01, day 0x01, and hours, minutes and seconds 0x00.
- R4: On each cycle where the tick strobe is high and no clock register is written, seconds advance by one in BCD. Seconds 0x59 wraps to 0x00 and carries into minutes. Minutes 0x59 wraps to 0x00 and carries into hours. Hours 0x23 wraps to 0x00 and carries into both day of week and date.
- R5: Day of week counts 0x01 to 0x07, and 0x07 wraps to 0x01.
- R6: When a carry reaches the date and the date is at or above the month length, the date becomes 0x01 and the month advances. The month length is 31 days, except 30 days for months 0x04, 0x06, 0x09 and 0x11, and 28 or 29 days for month 0x02.
- R7: February has 29 days when the year is a nonzero multiple of 4. It also has 29 days when the year is 0x00 and the century is a multiple of 4. In all other years it has 28 days.
- R8: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00 and advances the century in BCD. Century 0x99 wraps to 0x00.
- R9: A write cycle (ce_n=0, we_n=0 at a clock edge) to a clock address replaces that register with wdata. If the tick strobe is high in the same cycle, the tick is discarded for all registers.
- R10: A read access (ce_n=0, oe_n=0, we_n=1) loads rdata at the first edge of the access and again whenever the address changes. Otherwise rdata holds its value. rdata_en is high in each cycle that follows a cycle with a read access, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe per elapsed second |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W (15) | Byte address |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data snapshot |
| rdata_en | output | 1 | rdata holds valid read data for the current access |

## Verification
Counter state is only visible at the ports through reads, so an error in the carry chain shows up only when the affected register is read back. A wrong month length or leap decision stays hidden until a tick crosses that specific month end. For this reason the bench places the clock one second before each boundary, sends a single tick, and reads all the affected fields on the next access. A fault in snapshot or valid-flag handling shows on the first cycle after the access starts, so the bench compares rdata and rdata_en against a behavioural model on every clock.

// File: rtl/rtc_pkg.sv
// Package: shared constants and BCD helper for the memory-mapped calendar clock.
// Assumes 8-bit packed BCD registers and a register index equal to the low address bits.
package rtc_pkg;

    localparam int NREG      = 8;
    localparam int REG_AW    = 3;
    localparam int FLD_W     = 8;

    // register indices (low address bits in the clock window)
    localparam int IX_CEN  = 0;
    localparam int IX_SEC  = 1;
    localparam int IX_MIN  = 2;
    localparam int IX_HR   = 3;
    localparam int IX_DOW  = 4;
    localparam int IX_DATE = 5;
    localparam int IX_MON  = 6;
    localparam int IX_YR   = 7;

    localparam logic [FLD_W-1:0] FLD_RST [NREG] =
        '{8'h20, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    localparam logic [FLD_W-1:0] FLD_MIN [NREG] =
        '{8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    localparam logic [FLD_W-1:0] FLD_MAX [NREG] =
        '{8'h99, 8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99};

    // add one to a two-digit packed BCD value
    function automatic logic [FLD_W-1:0] bcd_inc(input logic [FLD_W-1:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
// Module: one BCD clock register with load, increment and wrap.
// Assumes limit is in BCD; the value wraps to MINV when at or above limit,
// so an out-of-range value written by the host still wraps on the next carry.
module rtc_bcd_field #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     MINV = '0,
    parameter logic [W-1:0]     RSTV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] limit,
    output logic [W-1:0] val,
    output logic         at_lim
);
    import rtc_pkg::*;

    // wrap condition for the carry chain
    assign at_lim = (val >= limit);

    // register update: load wins, otherwise count with wrap
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= RSTV;
        else if (ld)
            val <= ld_val;
        else if (inc)
            val <= at_lim ? MINV : bcd_inc(val);
    end

endmodule

// File: rtl/rtc_month_len.sv
// Module: last valid date of the current month, in BCD.
// Assumes BCD month/year/century; year 00 is a leap year only for a century divisible by 4.
module rtc_month_len #(
    parameter int W = 8
) (
    input  logic [W-1:0] month,
    input  logic [W-1:0] year,
    input  logic [W-1:0] century,
    output logic [W-1:0] last_date
);
    logic [5:0] yr_mod;
    logic [5:0] cen_mod;
    logic       yr_div4;
    logic       cen_div4;
    logic       leap;

    // residue mod 4 of a BCD value: (10*t + u) mod 4 = (2*t + u) mod 4
    always_comb begin
        yr_mod   = {1'b0, year[7:4], 1'b0} + {2'b00, year[3:0]};
        cen_mod  = {1'b0, century[7:4], 1'b0} + {2'b00, century[3:0]};
        yr_div4  = (yr_mod[1:0] == 2'b00);
        cen_div4 = (cen_mod[1:0] == 2'b00);
        leap     = yr_div4 && ((year != '0) || cen_div4);
    end

    // month length table
    always_comb begin
        case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_ram.sv
// Module: byte RAM behind the non-clock addresses.
// Assumes one write port and an asynchronous read of the same address; no reset.
module rtc_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // write port
    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
    end

    // read port
    assign rd = mem[addr];

endmodule

// File: rtl/bcd_rtc_sram.sv
// Module: top of the memory-mapped BCD calendar clock.
// Decodes the strobe bus, runs the seconds-to-century carry chain and
// registers a read snapshot. Assumes bus strobes are synchronous to clk.
module bcd_rtc_sram #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_en
);
    import rtc_pkg::*;

    localparam int FLAT_W = NREG * FLD_W;

    logic                 clk_sel;
    logic [REG_AW-1:0]    reg_ix;
    logic                 wr_cyc;
    logic                 rd_act;
    logic                 clk_wr;
    logic                 ram_wr;
    logic                 adv;
    logic [NREG-1:0]      inc;
    logic [NREG-1:0]      at_lim;
    logic [FLAT_W-1:0]    fld_flat;
    logic [FLD_W-1:0]     date_last;
    logic [DATA_W-1:0]    ram_rd;
    logic [DATA_W-1:0]    clk_rd;
    logic                 rd_q;
    logic [ADDR_W-1:0]    addr_q;

    // bus decode
    always_comb begin
        clk_sel = &addr[ADDR_W-1:REG_AW];
        reg_ix  = addr[REG_AW-1:0];
        wr_cyc  = !ce_n && !we_n;
        rd_act  = !ce_n && !oe_n && we_n;
        clk_wr  = wr_cyc && clk_sel;
        ram_wr  = wr_cyc && !clk_sel;
        adv     = tick_1hz && !clk_wr;
    end

    // carry chain from seconds up to century
    always_comb begin
        inc          = '0;
        inc[IX_SEC]  = adv;
        inc[IX_MIN]  = inc[IX_SEC]  && at_lim[IX_SEC];
        inc[IX_HR]   = inc[IX_MIN]  && at_lim[IX_MIN];
        inc[IX_DOW]  = inc[IX_HR]   && at_lim[IX_HR];
        inc[IX_DATE] = inc[IX_HR]   && at_lim[IX_HR];
        inc[IX_MON]  = inc[IX_DATE] && at_lim[IX_DATE];
        inc[IX_YR]   = inc[IX_MON]  && at_lim[IX_MON];
        inc[IX_CEN]  = inc[IX_YR]   && at_lim[IX_YR];
    end

    rtc_month_len #(.W(FLD_W)) u_mlen (
        .month     (fld_flat[IX_MON*FLD_W +: FLD_W]),
        .year      (fld_flat[IX_YR*FLD_W +: FLD_W]),
        .century   (fld_flat[IX_CEN*FLD_W +: FLD_W]),
        .last_date (date_last)
    );

    // one counter per clock register; the date limit follows the calendar
    for (genvar i = 0; i < NREG; i++) begin : g_fld
        logic [FLD_W-1:0] lim;
        if (i == IX_DATE) begin : g_dyn
            assign lim = date_last;
        end else begin : g_fix
            assign lim = FLD_MAX[i];
        end
        rtc_bcd_field #(
            .W    (FLD_W),
            .MINV (FLD_MIN[i]),
            .RSTV (FLD_RST[i])
        ) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[i]),
            .ld     (clk_wr && (reg_ix == REG_AW'(i))),
            .ld_val (wdata[FLD_W-1:0]),
            .limit  (lim),
            .val    (fld_flat[i*FLD_W +: FLD_W]),
            .at_lim (at_lim[i])
        );
    end

    rtc_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_wr),
        .addr  (addr[RAM_AW-1:0]),
        .wdata (wdata),
        .rd    (ram_rd)
    );

    // clock register read mux
    assign clk_rd = DATA_W'(fld_flat[{reg_ix, 3'b000} +: FLD_W]);

    // read snapshot: load at access start or on address change, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= 1'b0;
            addr_q   <= '0;
            rdata    <= '0;
            rdata_en <= 1'b0;
        end else begin
            rd_q     <= rd_act;
            addr_q   <= addr;
            rdata_en <= rd_act;
            if (rd_act && (!rd_q || (addr != addr_q)))
                rdata <= clk_sel ? clk_rd : ram_rd;
        end
    end

endmodule

// File: rtl/rtc_checker.sv
// Module: assertion checker for bcd_rtc_sram, attached by bind.
// Assumes the register flat vector orders registers by low address bits.
module rtc_checker #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_en,
    input logic [63:0]       fld_flat
);
    logic       rd_now;
    logic       cw;
    logic [2:0] wi_q;
    logic [7:0] wd_q;
    logic [7:0] wr_byte;
    logic [7:0] sec, mnt, hr, dow;

    always_comb begin
        rd_now  = !ce_n && !oe_n && we_n;
        cw      = !ce_n && !we_n && (&addr[ADDR_W-1:3]);
        sec     = fld_flat[15:8];
        mnt     = fld_flat[23:16];
        hr      = fld_flat[31:24];
        dow     = fld_flat[39:32];
        wr_byte = fld_flat[{wi_q, 3'b000} +: 8];
    end

    // remember the last clock write target and value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wi_q <= '0;
            wd_q <= '0;
        end else if (cw) begin
            wi_q <= addr[2:0];
            wd_q <= wdata[7:0];
        end
    end

    // R10: valid flag follows read access by one cycle
    a_r10_en_on: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now |=> rdata_en);
    a_r10_en_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |=> !rdata_en);
    // R10: continuing access at the same address keeps rdata
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_now && $past(rst_n) && $past(rd_now) && $stable(addr) |=> $stable(rdata));
    // R9: a clock write lands in the addressed register
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cw |=> (wr_byte == wd_q));
    // R9: tick coinciding with a write to another register leaves seconds alone
    a_r9_tick_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz && cw && (addr[2:0] != 3'd1) |=> $stable(sec));
    // R4: seconds wrap to zero
    a_r4_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz && !cw && (sec == 8'h59) |=> (sec == 8'h00));
    // R5: day of week wraps 7 to 1 at midnight
    a_r5_dow_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_1hz && !cw && (sec == 8'h59) && (mnt == 8'h59) && (hr == 8'h23)
        && (dow == 8'h07) |=> (dow == 8'h01));

endmodule

bind bcd_rtc_sram rtc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_1hz (tick_1hz),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .rdata_en (rdata_en),
    .fld_flat (fld_flat)
);

// File: tb/bcd_rtc_sram_test.sv
module bcd_rtc_sram_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        rdata_en;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string cur_req = "R3";

    always #10 clk = ~clk;

    bcd_rtc_sram uut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .ce_n(ce_n), .oe_n(oe_n),
        .we_n(we_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en)
    );

    // ---------------- behavioural reference model ----------------
    int         m_reg [8];          // decimal values by register index
    logic [7:0] m_ram [int];
    bit         m_rdq;
    logic [14:0] m_addrq;
    bit         exp_en;
    logic [7:0] exp_data;

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction
    function automatic int from_bcd(logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction
    function automatic int mlen(int mon, int yr, int cen);
        bit leap;
        leap = (yr % 4 == 0) && ((yr != 0) || (cen % 4 == 0));
        if (mon == 2) return leap ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic m_reset();
        m_reg = '{20, 0, 0, 0, 1, 1, 1, 0};
        m_rdq = 0; m_addrq = '0; exp_en = 0; exp_data = '0;
    endtask

    task automatic m_advance();
        bit c;
        if (m_reg[1] >= 59) begin m_reg[1] = 0; c = 1; end else begin m_reg[1]++; c = 0; end
        if (!c) return;
        if (m_reg[2] >= 59) begin m_reg[2] = 0; c = 1; end else begin m_reg[2]++; c = 0; end
        if (!c) return;
        if (m_reg[3] >= 23) begin m_reg[3] = 0; c = 1; end else begin m_reg[3]++; c = 0; end
        if (!c) return;
        if (m_reg[4] >= 7) m_reg[4] = 1; else m_reg[4]++;
        if (m_reg[5] >= mlen(m_reg[6], m_reg[7], m_reg[0])) begin m_reg[5] = 1; c = 1; end
        else begin m_reg[5]++; c = 0; end
        if (!c) return;
        if (m_reg[6] >= 12) begin m_reg[6] = 1; c = 1; end else begin m_reg[6]++; c = 0; end
        if (!c) return;
        if (m_reg[7] >= 99) begin m_reg[7] = 0; c = 1; end else begin m_reg[7]++; c = 0; end
        if (!c) return;
        if (m_reg[0] >= 99) m_reg[0] = 0; else m_reg[0]++;
    endtask

    always @(posedge clk) begin
        bit rd, wr, csel;
        if (!rst_n) begin
            m_reset();
        end else begin
            rd   = !ce_n && !oe_n && we_n;
            wr   = !ce_n && !we_n;
            csel = (addr[14:3] == 12'hFFF);
            if (rd && (!m_rdq || addr != m_addrq))
                exp_data = csel ? to_bcd(m_reg[addr[2:0]]) : m_ram[int'(addr) % 2048];
            exp_en  = rd;
            m_rdq   = rd;
            m_addrq = addr;
            if (wr && csel)       m_reg[addr[2:0]] = from_bcd(wdata);
            else if (tick_1hz)    m_advance();
            if (wr && !csel)      m_ram[int'(addr) % 2048] = wdata;
        end
    end

    // compare ports against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (rdata_en !== exp_en) begin
                n_fail++;
                $display("FAIL %s rdata_en actual=%0b expected=%0b", cur_req, rdata_en, exp_en);
            end
            if (exp_en) begin
                n_chk++;
                if (rdata !== exp_data) begin
                    n_fail++;
                    $display("FAIL %s rdata actual=%02h expected=%02h", cur_req, rdata, exp_data);
                end
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1; we_n = 1;
    endtask

    task automatic rd_exp(input logic [14:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(negedge clk);
        n_chk++;
        if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s read %04h actual=%02h expected=%02h", tag, a, rdata, e);
        end
        ce_n = 1; oe_n = 1;
    endtask

    task automatic tick1();
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
    endtask

    task automatic set_clk(input logic [7:0] cen, yr, mon, dt, dw, hr, mn, sc);
        wr(15'h7FF8, cen); wr(15'h7FFF, yr); wr(15'h7FFE, mon); wr(15'h7FFD, dt);
        wr(15'h7FFC, dw);  wr(15'h7FFB, hr); wr(15'h7FFA, mn);  wr(15'h7FF9, sc);
    endtask

    // set a date at 23:59:59, tick once, check the new date fields
    task automatic roll(input logic [7:0] cen, yr, mon, dt,
                        input logic [7:0] e_cen, e_yr, e_mon, e_dt, input string tag);
        cur_req = tag;
        set_clk(cen, yr, mon, dt, 8'h03, 8'h23, 8'h59, 8'h59);
        tick1();
        rd_exp(15'h7FFD, e_dt, tag);
        rd_exp(15'h7FFE, e_mon, tag);
        rd_exp(15'h7FFF, e_yr, tag);
        rd_exp(15'h7FF8, e_cen, tag);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R3 reset values through the R1 map
        cur_req = "R3";
        rd_exp(15'h7FF8, 8'h20, "R3"); rd_exp(15'h7FF9, 8'h00, "R3");
        rd_exp(15'h7FFA, 8'h00, "R3"); rd_exp(15'h7FFB, 8'h00, "R3");
        rd_exp(15'h7FFC, 8'h01, "R3"); rd_exp(15'h7FFD, 8'h01, "R3");
        rd_exp(15'h7FFE, 8'h01, "R3"); rd_exp(15'h7FFF, 8'h00, "R3");

        // R2 RAM storage, R1 aliasing and window edge
        cur_req = "R2";
        wr(15'h0000, 8'hA5); wr(15'h7FF7, 8'h3C); wr(15'h0123, 8'h5A);
        rd_exp(15'h0000, 8'hA5, "R2"); rd_exp(15'h7FF7, 8'h3C, "R2");
        rd_exp(15'h0123, 8'h5A, "R2");
        cur_req = "R1";
        wr(15'h0800, 8'h77);
        rd_exp(15'h0000, 8'h77, "R1");
        rd_exp(15'h7FF8, 8'h20, "R1");

        // R4 midnight carry
        cur_req = "R4";
        set_clk(8'h20, 8'h23, 8'h06, 8'h15, 8'h03, 8'h23, 8'h59, 8'h59);
        tick1();
        rd_exp(15'h7FF9, 8'h00, "R4"); rd_exp(15'h7FFA, 8'h00, "R4");
        rd_exp(15'h7FFB, 8'h00, "R4"); rd_exp(15'h7FFC, 8'h04, "R4");
        rd_exp(15'h7FFD, 8'h16, "R4");
        tick1(); tick1();
        rd_exp(15'h7FF9, 8'h02, "R4");
        wr(15'h7FF9, 8'h09); tick1();
        rd_exp(15'h7FF9, 8'h10, "R4");

        // R5 weekday wrap
        cur_req = "R5";
        set_clk(8'h20, 8'h23, 8'h06, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
        tick1();
        rd_exp(15'h7FFC, 8'h01, "R5");

        // R6 month ends
        roll(8'h20, 8'h23, 8'h01, 8'h31, 8'h20, 8'h23, 8'h02, 8'h01, "R6");
        roll(8'h20, 8'h23, 8'h03, 8'h30, 8'h20, 8'h23, 8'h03, 8'h31, "R6");
        roll(8'h20, 8'h23, 8'h04, 8'h30, 8'h20, 8'h23, 8'h05, 8'h01, "R6");
        roll(8'h20, 8'h23, 8'h11, 8'h30, 8'h20, 8'h23, 8'h12, 8'h01, "R6");
        roll(8'h20, 8'h23, 8'h04, 8'h31, 8'h20, 8'h23, 8'h05, 8'h01, "R6");

        // R7 leap years
        roll(8'h20, 8'h23, 8'h02, 8'h28, 8'h20, 8'h23, 8'h03, 8'h01, "R7");
        roll(8'h20, 8'h24, 8'h02, 8'h28, 8'h20, 8'h24, 8'h02, 8'h29, "R7");
        roll(8'h20, 8'h24, 8'h02, 8'h29, 8'h20, 8'h24, 8'h03, 8'h01, "R7");
        roll(8'h20, 8'h00, 8'h02, 8'h28, 8'h20, 8'h00, 8'h02, 8'h29, "R7");
        roll(8'h21, 8'h00, 8'h02, 8'h28, 8'h21, 8'h00, 8'h03, 8'h01, "R7");

        // R8 year and century
        roll(8'h19, 8'h99, 8'h12, 8'h31, 8'h20, 8'h00, 8'h01, 8'h01, "R8");
        roll(8'h20, 8'h19, 8'h12, 8'h31, 8'h20, 8'h20, 8'h01, 8'h01, "R8");
        roll(8'h99, 8'h99, 8'h12, 8'h31, 8'h00, 8'h00, 8'h01, 8'h01, "R8");

        // R9 write beats a simultaneous tick
        cur_req = "R9";
        set_clk(8'h20, 8'h23, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h10);
        @(negedge clk);
        ce_n = 0; we_n = 0; addr = 15'h7FF9; wdata = 8'h30; tick_1hz = 1;
        @(negedge clk);
        ce_n = 1; we_n = 1; tick_1hz = 0;
        rd_exp(15'h7FF9, 8'h30, "R9");
        @(negedge clk);
        ce_n = 0; we_n = 0; addr = 15'h7FFA; wdata = 8'h45; tick_1hz = 1;
        @(negedge clk);
        ce_n = 1; we_n = 1; tick_1hz = 0;
        rd_exp(15'h7FF9, 8'h30, "R9");
        rd_exp(15'h7FFA, 8'h45, "R9");

        // R10 snapshot held through a tick, reloaded on address change
        cur_req = "R10";
        @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; addr = 15'h7FF9;
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
        @(negedge clk);
        n_chk++;
        if (rdata !== 8'h30) begin
            n_fail++;
            $display("FAIL R10 held rdata actual=%02h expected=%02h", rdata, 8'h30);
        end
        addr = 15'h7FFA;
        @(negedge clk);
        n_chk++;
        if (rdata !== 8'h45) begin
            n_fail++;
            $display("FAIL R10 reload rdata actual=%02h expected=%02h", rdata, 8'h45);
        end
        ce_n = 1; oe_n = 1;
        @(negedge clk);
        n_chk++;
        if (rdata_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 rdata_en actual=%0b expected=0", rdata_en);
        end
        rd_exp(15'h7FF9, 8'h31, "R10");
        // output enable high: no read
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = 15'h7FF9;
        @(negedge clk);
        n_chk++;
        if (rdata_en !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 oe_n high rdata_en actual=%0b expected=0", rdata_en);
        end
        ce_n = 1;

        repeat (2) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule